// File: doc/BRIEF.md
# Multi-region flash sector locator with pending-erase map

This block turns a byte offset inside a parallel flash array into the sector that holds it. The array is built from up to four erase regions placed one after another from offset 0. Each region has its own sector count and a power-of-two sector length. A lookup returns the global sector number, the sector length and the sector base address one clock after the offset is presented. It also returns an error flag when the offset falls outside the array or when the geometry is illegal.

Geometry arrives on static configuration inputs. A region with a zero count ends the region list. When region 0 has a zero count, the block uses a separate uniform description instead: one sector count and one sector length for the whole device. The block checks every active region and reports a configuration error when any rule is broken.

Next to the locator sits a bitmap with one bit per sector. It records the sectors queued for erase. The erase command logic sets a bit for each sector-erase command it accepts. Suspend logic tests single bits. One strobe clears the whole map when the erase completes.

Top module: `flash_sector_map`

## Requirements
- R1: Active regions lie back to back from offset 0. Region i begins where region i-1 ends, and each region spans count times length bytes. For an offset inside region i, the sector number is the sum of the counts of regions 0..i-1 plus (offset minus region start) divided by the region's length.
- R2: A successful lookup returns the length of the matching region on `lk_len_o`. It returns the offset with its low log2(length) bits cleared on `lk_base_o`.
- R3: When region 0 has a count of zero, the device is one region described by `uni_cnt_i` and `uni_len_i`, and the counts of regions 1..3 are ignored. Otherwise the region list stops at the first region with a zero count.
- R4: An offset at or beyond the total array length gives `lk_err_o`=1 with `lk_num_o`, `lk_len_o` and `lk_base_o` all zero.
- R5: `cfg_err_o` is 1 when any active region's length breaks one of these rules: it must be a power of two, a multiple of 256, and below 2^24.
- R6: `cfg_err_o` is also 1 in each of these cases:
  - an active region's start is not a multiple of its own length;
  - the effective region 0 has a count of zero;
  - the total number of sectors exceeds MAX_SECTORS.
  A lookup issued while `cfg_err_o` is 1 returns the error result of R4.
- R7: Lookup results are registered. `lk_vld_o` equals `lk_req_i` of the previous cycle. The result outputs change only in the cycle after a request and hold their values otherwise.
- R8: When `set_i` is 1 and `set_num_i` is below MAX_SECTORS, the pending-erase bit of that sector is set. A `set_num_i` at or above MAX_SECTORS changes no bit. `test_hit_o` shows the bit selected by `test_num_i` combinationally, and shows 0 for numbers at or above MAX_SECTORS.
- R9: When a set and a test address the same sector in the same cycle, `test_hit_o` shows the old bit value. The new value appears from the next cycle.
- R10: When `clr_i` is 1, every pending-erase bit is 0 from the next cycle. A clear wins over a set in the same cycle.
- R11: After reset the map is empty, and `lk_vld_o`, `lk_err_o` and all lookup result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_cnt_i | input | NUM_REGIONS*CNT_W | Sector count per region, region i in bits [i*CNT_W +: CNT_W] |
| reg_len_i | input | NUM_REGIONS*LEN_W | Sector length in bytes per region, region i in bits [i*LEN_W +: LEN_W] |
| uni_cnt_i | input | CNT_W | Sector count used when region 0 count is zero |
| uni_len_i | input | LEN_W | Sector length used when region 0 count is zero |
| cfg_err_o | output | 1 | Geometry breaks a length, alignment, count or capacity rule |
| lk_req_i | input | 1 | Lookup request |
| lk_off_i | input | ADDR_W | Byte offset to look up |
| lk_vld_o | output | 1 | Lookup result valid, one cycle after the request |
| lk_err_o | output | 1 | Offset out of range or geometry illegal |
| lk_num_o | output | SNUM_W | Global sector number |
| lk_len_o | output | LEN_W | Sector length in bytes |
| lk_base_o | output | ADDR_W | Sector base address |
| set_i | input | 1 | Mark a sector as pending erase |
| set_num_i | input | SNUM_W | Sector number to mark |
| test_num_i | input | SNUM_W | Sector number to test |
| test_hit_o | output | 1 | Pending-erase bit of the tested sector |
| clr_i | input | 1 | Clear all pending-erase bits |

## Verification
The hardest results to reach from the ports are the sector numbers near region seams. These depend on the running sum of earlier counts and on a shift that changes with each region. They are only exercised by geometries with several regions of different lengths that still obey the alignment rule. The stimulus builds random four-region layouts whose lengths never grow from one region to the next, so every start stays aligned. It mixes in uniform layouts and deliberately misaligned or malformed ones. It also targets offsets at the last byte of each region and one past the end of the array. The bitmap is driven with random sets, tests and clears, including a set and a test on the same sector in the same cycle.

// File: rtl/flash_sector_map_pkg.sv
package flash_sector_map_pkg;

  // Index of the highest set bit, 0 when v is zero.
  function automatic logic [5:0] msb_pos(input logic [31:0] v);
    msb_pos = '0;
    for (int k = 0; k < 32; k++) begin
      if (v[k]) msb_pos = 6'(k);
    end
  endfunction

endpackage

// File: rtl/sector_geom.sv
module sector_geom
  import flash_sector_map_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int CNT_W       = 8,
  parameter int LEN_W       = 25,
  parameter int MAX_SECTORS = 64,
  localparam int SPAN_W     = CNT_W + LEN_W,
  localparam int ST_W       = SPAN_W + 2,
  localparam int SNUM_W     = CNT_W + 2
) (
  input  logic [NUM_REGIONS*CNT_W-1:0] reg_cnt_i,
  input  logic [NUM_REGIONS*LEN_W-1:0] reg_len_i,
  input  logic [CNT_W-1:0]             uni_cnt_i,
  input  logic [LEN_W-1:0]             uni_len_i,
  output logic                         act_o   [NUM_REGIONS],
  output logic [ST_W-1:0]              start_o [NUM_REGIONS],
  output logic [SPAN_W-1:0]            span_o  [NUM_REGIONS],
  output logic [5:0]                   l2_o    [NUM_REGIONS],
  output logic [SNUM_W-1:0]            first_o [NUM_REGIONS],
  output logic [LEN_W-1:0]             len_o   [NUM_REGIONS],
  output logic                         cfg_err_o
);

  localparam logic [SNUM_W-1:0] MAX_N = SNUM_W'(MAX_SECTORS);

  logic             uniform;
  logic [CNT_W-1:0] eff_cnt  [NUM_REGIONS];
  logic             len_bad  [NUM_REGIONS];
  logic             algn_bad [NUM_REGIONS];
  logic [SNUM_W-1:0] tot_sec;

  assign uniform = (reg_cnt_i[CNT_W-1:0] == '0);

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_reg
    logic [LEN_W-1:0] len_w;
    if (i == 0) begin : g_first
      assign eff_cnt[i] = uniform ? uni_cnt_i : reg_cnt_i[CNT_W-1:0];
      assign len_w      = uniform ? uni_len_i : reg_len_i[LEN_W-1:0];
      assign act_o[i]   = 1'b1;
    end else begin : g_rest
      assign eff_cnt[i] = uniform ? '0 : reg_cnt_i[i*CNT_W +: CNT_W];
      assign len_w      = uniform ? '0 : reg_len_i[i*LEN_W +: LEN_W];
      assign act_o[i]   = act_o[i-1] && (eff_cnt[i] != '0);
    end
    assign len_o[i]  = len_w;
    assign l2_o[i]   = msb_pos(32'(len_w));
    assign span_o[i] = SPAN_W'(eff_cnt[i]) << l2_o[i];
    assign len_bad[i] = act_o[i] &&
                        ((len_w == '0) ||
                         ((len_w & (len_w - 1'b1)) != '0) ||
                         (len_w[7:0] != '0) ||
                         (len_w[LEN_W-1:24] != '0));
    assign algn_bad[i] = act_o[i] &&
                         ((start_o[i] & (ST_W'(len_w) - 1'b1)) != '0);
  end

  always_comb begin
    start_o[0] = '0;
    first_o[0] = '0;
    tot_sec    = SNUM_W'(eff_cnt[0]);
    for (int i = 1; i < NUM_REGIONS; i++) begin
      start_o[i] = start_o[i-1] + (act_o[i-1] ? ST_W'(span_o[i-1]) : '0);
      first_o[i] = first_o[i-1] + SNUM_W'(eff_cnt[i-1]);
      if (act_o[i]) tot_sec = tot_sec + SNUM_W'(eff_cnt[i]);
    end
  end

  always_comb begin
    cfg_err_o = (eff_cnt[0] == '0) || (tot_sec > MAX_N);
    for (int i = 0; i < NUM_REGIONS; i++) begin
      cfg_err_o = cfg_err_o | len_bad[i] | algn_bad[i];
    end
  end

endmodule

// File: rtl/sector_locate.sv
module sector_locate #(
  parameter int NUM_REGIONS = 4,
  parameter int ADDR_W      = 20,
  parameter int CNT_W       = 8,
  parameter int LEN_W       = 25,
  localparam int SPAN_W     = CNT_W + LEN_W,
  localparam int ST_W       = SPAN_W + 2,
  localparam int SNUM_W     = CNT_W + 2,
  localparam int SEL_W      = $clog2(NUM_REGIONS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i   [NUM_REGIONS],
  input  logic [ST_W-1:0]   start_i [NUM_REGIONS],
  input  logic [SPAN_W-1:0] span_i  [NUM_REGIONS],
  input  logic [5:0]        l2_i    [NUM_REGIONS],
  input  logic [SNUM_W-1:0] first_i [NUM_REGIONS],
  input  logic [LEN_W-1:0]  len_i   [NUM_REGIONS],
  input  logic              cfg_err_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] off_i,
  output logic              vld_o,
  output logic              err_o,
  output logic [SNUM_W-1:0] num_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [ADDR_W-1:0] base_o
);

  logic [ST_W-1:0]   off_x;
  logic              hit [NUM_REGIONS];
  logic              found;
  logic [SEL_W-1:0]  sel;
  logic [ST_W-1:0]   rel, idx;
  logic [SNUM_W-1:0] num_d;
  logic [ADDR_W-1:0] mask, base_d;
  logic              err_d;

  assign off_x = ST_W'(off_i);

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_hit
    assign hit[i] = act_i[i] && (off_x >= start_i[i]) &&
                    (off_x < start_i[i] + ST_W'(span_i[i]));
  end

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found = 1'b1;
        sel   = SEL_W'(i);
      end
    end
  end

  assign rel    = off_x - start_i[sel];
  assign idx    = rel >> l2_i[sel];
  assign num_d  = first_i[sel] + idx[SNUM_W-1:0];
  assign mask   = ADDR_W'(len_i[sel]) - 1'b1;
  assign base_d = off_i & ~mask;
  assign err_d  = cfg_err_i || !found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      err_o  <= 1'b0;
      num_o  <= '0;
      len_o  <= '0;
      base_o <= '0;
    end else begin
      vld_o <= req_i;
      if (req_i) begin
        err_o  <= err_d;
        num_o  <= err_d ? '0 : num_d;
        len_o  <= err_d ? '0 : len_i[sel];
        base_o <= err_d ? '0 : base_d;
      end
    end
  end

endmodule

// File: rtl/erase_map.sv
module erase_map #(
  parameter int MAX_SECTORS = 64,
  parameter int SNUM_W      = 10,
  localparam int IDX_W      = $clog2(MAX_SECTORS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [SNUM_W-1:0] set_num_i,
  input  logic [SNUM_W-1:0] test_num_i,
  input  logic              clr_i,
  output logic              test_hit_o
);

  localparam logic [SNUM_W-1:0] MAX_N = SNUM_W'(MAX_SECTORS);

  logic [MAX_SECTORS-1:0] pend_q;
  logic                   set_ok;

  assign set_ok = set_i && (set_num_i < MAX_N);

  for (genvar s = 0; s < MAX_SECTORS; s++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          pend_q[s] <= 1'b0;
      else if (clr_i)                                       pend_q[s] <= 1'b0;
      else if (set_ok && (set_num_i[IDX_W-1:0] == IDX_W'(s))) pend_q[s] <= 1'b1;
    end
  end

  assign test_hit_o = (test_num_i < MAX_N) ? pend_q[test_num_i[IDX_W-1:0]] : 1'b0;

endmodule

// File: rtl/flash_sector_map.sv
module flash_sector_map #(
  parameter int NUM_REGIONS = 4,
  parameter int ADDR_W      = 20,
  parameter int CNT_W       = 8,
  parameter int LEN_W       = 25,
  parameter int MAX_SECTORS = 64,
  localparam int SPAN_W     = CNT_W + LEN_W,
  localparam int ST_W       = SPAN_W + 2,
  localparam int SNUM_W     = CNT_W + 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_REGIONS*CNT_W-1:0] reg_cnt_i,
  input  logic [NUM_REGIONS*LEN_W-1:0] reg_len_i,
  input  logic [CNT_W-1:0]             uni_cnt_i,
  input  logic [LEN_W-1:0]             uni_len_i,
  output logic                         cfg_err_o,
  input  logic                         lk_req_i,
  input  logic [ADDR_W-1:0]            lk_off_i,
  output logic                         lk_vld_o,
  output logic                         lk_err_o,
  output logic [SNUM_W-1:0]            lk_num_o,
  output logic [LEN_W-1:0]             lk_len_o,
  output logic [ADDR_W-1:0]            lk_base_o,
  input  logic                         set_i,
  input  logic [SNUM_W-1:0]            set_num_i,
  input  logic [SNUM_W-1:0]            test_num_i,
  output logic                         test_hit_o,
  input  logic                         clr_i
);

  logic              act   [NUM_REGIONS];
  logic [ST_W-1:0]   start [NUM_REGIONS];
  logic [SPAN_W-1:0] span  [NUM_REGIONS];
  logic [5:0]        l2    [NUM_REGIONS];
  logic [SNUM_W-1:0] first [NUM_REGIONS];
  logic [LEN_W-1:0]  len   [NUM_REGIONS];

  sector_geom #(
    .NUM_REGIONS(NUM_REGIONS), .CNT_W(CNT_W), .LEN_W(LEN_W),
    .MAX_SECTORS(MAX_SECTORS)
  ) u_geom (
    .reg_cnt_i(reg_cnt_i), .reg_len_i(reg_len_i),
    .uni_cnt_i(uni_cnt_i), .uni_len_i(uni_len_i),
    .act_o(act), .start_o(start), .span_o(span), .l2_o(l2),
    .first_o(first), .len_o(len), .cfg_err_o(cfg_err_o)
  );

  sector_locate #(
    .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W)
  ) u_loc (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .act_i(act), .start_i(start), .span_i(span), .l2_i(l2),
    .first_i(first), .len_i(len), .cfg_err_i(cfg_err_o),
    .req_i(lk_req_i), .off_i(lk_off_i),
    .vld_o(lk_vld_o), .err_o(lk_err_o), .num_o(lk_num_o),
    .len_o(lk_len_o), .base_o(lk_base_o)
  );

  erase_map #(
    .MAX_SECTORS(MAX_SECTORS), .SNUM_W(SNUM_W)
  ) u_map (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(set_i), .set_num_i(set_num_i),
    .test_num_i(test_num_i), .clr_i(clr_i),
    .test_hit_o(test_hit_o)
  );

endmodule

// File: rtl/flash_sector_map_chk.sv
module flash_sector_map_chk #(
  parameter int ADDR_W      = 20,
  parameter int LEN_W       = 25,
  parameter int SNUM_W      = 10,
  parameter int MAX_SECTORS = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_err_o,
  input logic              lk_req_i,
  input logic              lk_vld_o,
  input logic              lk_err_o,
  input logic [SNUM_W-1:0] lk_num_o,
  input logic [LEN_W-1:0]  lk_len_o,
  input logic [ADDR_W-1:0] lk_base_o,
  input logic              set_i,
  input logic [SNUM_W-1:0] set_num_i,
  input logic [SNUM_W-1:0] test_num_i,
  input logic              test_hit_o,
  input logic              clr_i
);

  localparam logic [SNUM_W-1:0] MAX_N = SNUM_W'(MAX_SECTORS);

  logic [ADDR_W-1:0] len_mask;
  assign len_mask = lk_len_o[ADDR_W-1:0] - 1'b1;

  p_vld_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_i |=> lk_vld_o);

  p_vld_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_req_i |=> !lk_vld_o);

  p_len_pow2_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_vld_o && !lk_err_o) |-> ($countones(lk_len_o) == 1));

  p_base_align_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_vld_o && !lk_err_o) |-> ((lk_base_o & len_mask) == '0));

  p_err_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_vld_o && lk_err_o) |->
      (lk_num_o == '0 && lk_len_o == '0 && lk_base_o == '0));

  p_cfg_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_req_i && cfg_err_o) |=> lk_err_o);

  p_set_seen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i && set_num_i < MAX_N && set_num_i == test_num_i) |=>
      (!$stable(test_num_i) || test_hit_o));

  p_clr_all_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !test_hit_o);

endmodule

bind flash_sector_map flash_sector_map_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SNUM_W(SNUM_W), .MAX_SECTORS(MAX_SECTORS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_err_o(cfg_err_o),
  .lk_req_i(lk_req_i), .lk_vld_o(lk_vld_o), .lk_err_o(lk_err_o),
  .lk_num_o(lk_num_o), .lk_len_o(lk_len_o), .lk_base_o(lk_base_o),
  .set_i(set_i), .set_num_i(set_num_i), .test_num_i(test_num_i),
  .test_hit_o(test_hit_o), .clr_i(clr_i)
);

// File: tb/flash_sector_map_test.sv
module flash_sector_map_test;

  localparam int NR     = 4;
  localparam int ADDR_W = 20;
  localparam int CNT_W  = 8;
  localparam int LEN_W  = 25;
  localparam int MAXS   = 64;
  localparam int SNUM_W = CNT_W + 2;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [NR*CNT_W-1:0]   reg_cnt = '0;
  logic [NR*LEN_W-1:0]   reg_len = '0;
  logic [CNT_W-1:0]      uni_cnt = '0;
  logic [LEN_W-1:0]      uni_len = '0;
  logic                  cfg_err;
  logic                  lk_req = 1'b0;
  logic [ADDR_W-1:0]     lk_off = '0;
  logic                  lk_vld, lk_err;
  logic [SNUM_W-1:0]     lk_num;
  logic [LEN_W-1:0]      lk_len;
  logic [ADDR_W-1:0]     lk_base;
  logic                  set_r = 1'b0;
  logic [SNUM_W-1:0]     set_num = '0;
  logic [SNUM_W-1:0]     test_num = '0;
  logic                  test_hit;
  logic                  clr = 1'b0;

  always #2 clk = ~clk;

  flash_sector_map uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_cnt_i(reg_cnt), .reg_len_i(reg_len),
    .uni_cnt_i(uni_cnt), .uni_len_i(uni_len), .cfg_err_o(cfg_err),
    .lk_req_i(lk_req), .lk_off_i(lk_off),
    .lk_vld_o(lk_vld), .lk_err_o(lk_err), .lk_num_o(lk_num),
    .lk_len_o(lk_len), .lk_base_o(lk_base),
    .set_i(set_r), .set_num_i(set_num), .test_num_i(test_num),
    .test_hit_o(test_hit), .clr_i(clr)
  );

  int     n_run = 0;
  int     n_bad = 0;
  int     c_cnt [NR];
  longint c_len [NR];
  int     u_cnt;
  longint u_len;
  bit     exp_map [MAXS];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_run++;
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  // Independent model of the geometry rules.
  task automatic model(input longint off, output bit bad, output bit err,
                       output longint num, output longint len, output longint base);
    int     ec [NR];
    longint el [NR];
    int     nreg;
    longint st, fs, tot;
    bad = 0; err = 0; num = 0; len = 0; base = 0;
    for (int i = 0; i < NR; i++) begin ec[i] = 0; el[i] = 0; end
    if (c_cnt[0] == 0) begin
      nreg = 1; ec[0] = u_cnt; el[0] = u_len;
    end else begin
      nreg = 0;
      for (int i = 0; i < NR; i++) begin
        if (nreg == i && c_cnt[i] != 0) begin
          nreg++; ec[i] = c_cnt[i]; el[i] = c_len[i];
        end
      end
    end
    st = 0; tot = 0;
    for (int i = 0; i < nreg; i++) begin
      if (el[i] == 0 || (el[i] & (el[i] - 1)) != 0 || el[i] % 256 != 0 ||
          el[i] >= (64'd1 << 24))
        bad = 1;
      else if (st % el[i] != 0)
        bad = 1;
      st  += ec[i] * el[i];
      tot += ec[i];
    end
    if (ec[0] == 0 || tot > MAXS) bad = 1;
    if (bad) begin err = 1; return; end
    st = 0; fs = 0; err = 1;
    for (int i = 0; i < nreg; i++) begin
      if (err && off >= st && off < st + ec[i] * el[i]) begin
        err = 0;
        num = fs + (off - st) / el[i];
        len = el[i];
        base = off - (off % el[i]);
      end
      st += ec[i] * el[i];
      fs += ec[i];
    end
  endtask

  task automatic apply_cfg();
    bit b, e; longint n, l, ba;
    @(negedge clk);
    for (int i = 0; i < NR; i++) begin
      reg_cnt[i*CNT_W +: CNT_W] = c_cnt[i][CNT_W-1:0];
      reg_len[i*LEN_W +: LEN_W] = c_len[i][LEN_W-1:0];
    end
    uni_cnt = u_cnt[CNT_W-1:0];
    uni_len = u_len[LEN_W-1:0];
    #1;
    model(0, b, e, n, l, ba);
    chk(cfg_err == b, "R5 R6 cfg_err", longint'(cfg_err), longint'(b));
  endtask

  task automatic look(input longint off);
    bit b, e; longint n, l, ba;
    logic [SNUM_W-1:0] held;
    model(off, b, e, n, l, ba);
    @(negedge clk);
    lk_req = 1'b1;
    lk_off = off[ADDR_W-1:0];
    @(negedge clk);
    lk_req = 1'b0;
    chk(lk_vld == 1'b1, "R7 vld", longint'(lk_vld), 1);
    if (e) begin
      chk(lk_err && lk_num == 0 && lk_len == 0 && lk_base == 0,
          b ? "R6 err on bad cfg" : "R4 out of range",
          {lk_err, 20'(lk_num)}, {1'b1, 20'h0});
    end else begin
      chk(!lk_err && lk_num == n[SNUM_W-1:0], "R1 sector number", longint'(lk_num), n);
      chk(lk_len == l[LEN_W-1:0] && lk_base == ba[ADDR_W-1:0], "R2 len/base",
          longint'(lk_base), ba);
    end
    held = lk_num;
    @(negedge clk);
    chk(!lk_vld && lk_num == held, "R7 idle hold", longint'(lk_num), longint'(held));
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < NR; i++) begin c_cnt[i] = 0; c_len[i] = 0; end
    u_cnt = 0; u_len = 0;
  endtask

  task automatic map_step(input bit s, input int sn, input int tn, input bit c, input string req);
    @(negedge clk);
    set_r = s; set_num = sn[SNUM_W-1:0]; test_num = tn[SNUM_W-1:0]; clr = c;
    #1;
    chk(test_hit == ((tn < MAXS) ? exp_map[tn] : 1'b0), req, longint'(test_hit),
        longint'((tn < MAXS) ? exp_map[tn] : 1'b0));
    @(posedge clk);
    if (c) for (int k = 0; k < MAXS; k++) exp_map[k] = 0;
    else if (s && sn < MAXS) exp_map[sn] = 1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < MAXS; k++) exp_map[k] = 0;
    clear_cfg();
    repeat (3) @(negedge clk);
    #1;
    chk(!lk_vld && !lk_err && lk_num == 0 && lk_len == 0 && lk_base == 0,
        "R11 lookup reset", longint'(lk_vld), 0);
    rst_n = 1'b1;
    map_step(0, 0, 0, 0, "R11 map empty");
    map_step(0, 0, 63, 0, "R11 map empty");

    // R3 uniform device, region counts above 0 ignored
    clear_cfg(); c_cnt[1] = 5; c_len[1] = 256; u_cnt = 16; u_len = 4096;
    apply_cfg();
    look(20'h3FFF); look(20'hFFFF); look(20'h10000);

    // R1 four regions with falling lengths
    clear_cfg();
    c_cnt[0] = 2; c_len[0] = 'h4000; c_cnt[1] = 3; c_len[1] = 'h1000;
    c_cnt[2] = 4; c_len[2] = 'h400;  c_cnt[3] = 8; c_len[3] = 'h100;
    apply_cfg();
    look(0); look(20'h7FFF); look(20'h8000); look(20'hB3FF);
    look(20'hC000); look(20'hC7FF); look(20'hC800);

    // R3 list ends at first zero count
    c_cnt[1] = 0;
    apply_cfg();
    look(20'h7FFF); look(20'h8000);

    // R5 length rule breaks
    clear_cfg(); c_cnt[0] = 1; c_len[0] = 'h180; apply_cfg(); look(0);
    c_len[0] = 'h80; apply_cfg();
    c_len[0] = 64'd1 << 24; apply_cfg();
    // R6 misaligned start, zero uniform count, too many sectors
    clear_cfg(); c_cnt[0] = 1; c_len[0] = 'h100; c_cnt[1] = 1; c_len[1] = 'h1000;
    apply_cfg(); look(20'h100);
    clear_cfg(); u_len = 'h100; apply_cfg();
    clear_cfg(); u_cnt = 65; u_len = 'h100; apply_cfg(); look(0);

    // random geometries
    for (int t = 0; t < 60; t++) begin
      int mode, l2;
      clear_cfg();
      mode = $urandom % 4;
      l2 = 8 + $urandom % 6;
      for (int i = 0; i < NR; i++) begin
        c_cnt[i] = 1 + $urandom % 15;
        case (mode)
          0: begin c_len[i] = 64'd1 << l2; if (l2 > 8) l2 -= $urandom % 2; end
          2: c_len[i] = longint'($urandom % 32'h10000);
          default: begin c_len[i] = 64'd1 << l2; if (l2 < 13) l2 += 1; end
        endcase
      end
      if ($urandom % 4 == 0) c_cnt[3] = 0;
      if (mode == 1) begin
        c_cnt[0] = 0; u_cnt = 1 + $urandom % 64; u_len = 64'd1 << (8 + $urandom % 6);
      end
      apply_cfg();
      for (int j = 0; j < 6; j++)
        look(longint'($urandom & ((32'd1 << (14 + $urandom % 6)) - 1)));
    end

    // R8 set and out-of-range set ignored
    map_step(1, 6, 6, 0, "R8 set");
    map_step(0, 0, 6, 0, "R8 set visible");
    map_step(1, 70, 7, 0, "R8 high set ignored");
    map_step(0, 0, 7, 0, "R8 high set ignored");
    map_step(0, 0, 70, 0, "R8 high test zero");
    // R9 same-cycle set/test shows old value, then new value
    map_step(1, 20, 20, 0, "R9 old value");
    map_step(0, 0, 20, 0, "R9 new value");
    // R10 clear beats set
    map_step(1, 33, 33, 1, "R10 clear with set");
    map_step(0, 0, 33, 0, "R10 clear wins");
    map_step(0, 0, 20, 0, "R10 all cleared");

    for (int t = 0; t < 400; t++) begin
      int r = $urandom % 16;
      int sn = $urandom % 72;
      map_step(r < 9, sn, ($urandom % 2) ? sn : $urandom % 72, r == 15, "R8 R9 R10 random map");
    end
    map_step(0, 0, 0, 0, "R10 final");
    finish_run();
  end

endmodule